// File: doc/BRIEF.md
# Raster-Synchronized Copper Coprocessor

This block is a small coprocessor that steps through a program held in its own 16-bit program store while the display beam sweeps the screen. Each instruction is one or two words. An instruction can put an immediate word, or a word taken from the program store, onto an extended-register write bus. It can stall until the beam reaches a horizontal or vertical position. It can also branch on a borrow flag. A 16-bit accumulator and its borrow flag sit behind three reserved bus addresses. Writing to one of these addresses loads, subtracts or compares instead of driving the bus, so short loops and counters can be run from the program itself.

The display pipeline feeds the block the beam position, an end-of-line strobe and the blitter busy level. A host fills the program store through a plain write port while the block is disabled. Each frame-start strobe, and every period with the enable low, sends execution back to word 0 and clears the borrow flag.

The control path is a six-state machine. IDLE goes to FETCH once enabled. FETCH (read word at PC) goes to DECODE (latch first word, read PC+1). DECODE goes to OPER (latch second word, read source word). OPER goes to EXEC (act). EXEC goes back to FETCH, or to WAIT when a position wait is not yet met. WAIT stays in WAIT until the condition holds and then goes to FETCH. Enable low forces IDLE from any state. A frame-start strobe forces FETCH from any state.

Top module: `raster_copper`

## Requirements
- R1: While `en` is low the bus write strobe stays low, the PC is held at 0 and borrow is 0. After `en` rises, execution begins with the word at address 0.
- R2: A first word with bits [13:12]=00 is a set-immediate. Its bus target is {bits[15:14], 2'b00, bits[11:0]} and the second word is the data written.
- R3: A first word with bits [13:12]=01 is a copy. Bits [11:0] give the source address in the program store, the second word is the bus target, and the source word is the data written.
- R4: When a copy's source field has bit 11 set, the data is the accumulator value, and borrow does not change.
- R5: A write to target 0xC800 loads the accumulator and clears borrow. It produces no bus write.
- R6: A write to target 0xC801 sets borrow to (accumulator < value) and replaces the accumulator with accumulator minus value, modulo 2^16. It produces no bus write.
- R7: A write to target 0xC7FF sets borrow to (accumulator < value) and leaves the accumulator unchanged. It produces no bus write.
- R8: Bits [13:11]=100 form a horizontal wait on bits [10:0]. It stalls until `h_pos` >= value or `eol` is high.
- R9: Bits [13:11]=101 form a vertical wait. It stalls until `v_pos` >= bits [9:0]. When bit 10 is set, it also ends as soon as `blit_busy` is low.
- R10: Bits [13:11]=110 jump to bits [10:0] when borrow is 0. Bits [13:11]=111 jump there when borrow is 1. Otherwise execution continues with the next word.
- R11: Every instruction that does not wait takes exactly 4 cycles, and its bus write appears in the fourth. The PC advances by 2 after a set or copy and by 1 after a wait or a branch not taken.
- R12: An `frame_start` strobe while enabled restarts at address 0 on the next cycle, clears borrow, cancels any write in that cycle and keeps the accumulator.
- R13: The host port writes a program word at the next clock edge. Program-store reads at addresses at or beyond the store depth (1536 words) return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; one cycle per native pixel |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low holds the block idle at address 0 |
| frame_start | input | 1 | Start-of-frame strobe, restarts the program |
| h_pos | input | 11 | Current horizontal beam position |
| v_pos | input | 11 | Current vertical beam position |
| eol | input | 1 | End-of-line strobe |
| blit_busy | input | 1 | Blitter busy level |
| cm_wr_en | input | 1 | Host program-store write strobe |
| cm_wr_addr | input | 11 | Host program-store write address |
| cm_wr_data | input | 16 | Host program-store write data |
| xr_wr_en | output | 1 | Extended-register bus write strobe |
| xr_wr_addr | output | 16 | Extended-register bus address |
| xr_wr_data | output | 16 | Extended-register bus data |

## Verification
A bus write is due in the fourth cycle after the instruction fetch begins. When `en` is raised at one falling edge, the first write therefore shows at the fourth falling edge after it. A wait that finds its condition met releases the next fetch on the following edge. The bench samples outputs one time unit after each falling edge and compares them there against a behavioural model that counts phases 0 to 3 per instruction, so every cycle is checked rather than a window. Directed checks on the log of bus writes then confirm the data that arithmetic, branches, early vertical-wait exit and restarts should produce.

// File: rtl/copper_pkg.sv
package copper_pkg;
    localparam int PC_W  = 11;
    localparam int POS_W = 11;
    localparam int DW    = 16;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_DECODE, S_OPER, S_EXEC, S_WAIT
    } cop_state_e;

    typedef enum logic [1:0] {
        K_SETI   = 2'b00,
        K_SETM   = 2'b01,
        K_WAIT   = 2'b10,
        K_BRANCH = 2'b11
    } instr_kind_e;

    typedef enum logic [1:0] {
        ACC_NONE, ACC_LOAD, ACC_SUB, ACC_CMP
    } acc_op_e;

    localparam logic [DW-1:0] XR_ACC_LOAD = 16'hC800;
    localparam logic [DW-1:0] XR_ACC_SUB  = 16'hC801;
    localparam logic [DW-1:0] XR_ACC_CMP  = 16'hC7FF;
endpackage

// File: rtl/copper_mem.sv
module copper_mem #(
    parameter int DEPTH = 1536,
    parameter int AW    = 11,
    parameter int DW    = 16
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam logic [AW:0] LIMIT = (AW+1)'(DEPTH);

    logic [DW-1:0] store [DEPTH];

    // R13: host writes land at the next edge; out-of-range reads give zero
    always_ff @(posedge clk) begin
        if (wr_en && ({1'b0, wr_addr} < LIMIT)) begin
            store[wr_addr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if ({1'b0, rd_addr} < LIMIT) begin
            rd_data <= store[rd_addr];
        end else begin
            rd_data <= '0;
        end
    end
endmodule

// File: rtl/copper_decode.sv
module copper_decode
    import copper_pkg::*;
(
    input  logic [DW-1:0]    ir,
    input  logic [POS_W-1:0] h_pos,
    input  logic [POS_W-1:0] v_pos,
    input  logic             eol,
    input  logic             blit_busy,
    input  logic             borrow,
    output instr_kind_e      kind,
    output logic [DW-1:0]    seti_target,
    output logic             src_is_acc,
    output logic [PC_W-1:0]  src_addr,
    output logic             wait_met,
    output logic             branch_taken,
    output logic [PC_W-1:0]  branch_target
);
    logic h_met;
    logic v_met;

    always_comb begin
        kind          = instr_kind_e'(ir[13:12]);
        seti_target   = {ir[15:14], 2'b00, ir[11:0]};
        src_is_acc    = ir[11];
        src_addr      = ir[PC_W-1:0];
        h_met         = (h_pos >= ir[10:0]) || eol;
        v_met         = (v_pos >= {1'b0, ir[9:0]}) || (ir[10] && !blit_busy);
        wait_met      = ir[11] ? v_met : h_met;
        branch_taken  = ir[11] ? borrow : !borrow;
        branch_target = ir[PC_W-1:0];
    end
endmodule

// File: rtl/copper_acc.sv
module copper_acc
    import copper_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  acc_op_e       op,
    input  logic [DW-1:0] val,
    input  logic          clr_b,
    output logic [DW-1:0] acc,
    output logic          borrow
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc    <= '0;
            borrow <= 1'b0;
        end else begin
            unique case (op)
                ACC_LOAD: acc <= val;
                ACC_SUB:  acc <= acc - val;
                default:  acc <= acc;
            endcase
            if (clr_b) begin
                borrow <= 1'b0;
            end else begin
                unique case (op)
                    ACC_LOAD:         borrow <= 1'b0;
                    ACC_SUB, ACC_CMP: borrow <= (acc < val);
                    default:          borrow <= borrow;
                endcase
            end
        end
    end

    assert_cmp_keeps_acc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        op == ACC_CMP |=> $stable(acc));

    assert_load_clears_borrow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        op == ACC_LOAD |=> !borrow);
endmodule

// File: rtl/raster_copper.sv
module raster_copper
    import copper_pkg::*;
#(
    parameter int CMEM_DEPTH = 1536
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             frame_start,
    input  logic [10:0]      h_pos,
    input  logic [10:0]      v_pos,
    input  logic             eol,
    input  logic             blit_busy,
    input  logic             cm_wr_en,
    input  logic [10:0]      cm_wr_addr,
    input  logic [15:0]      cm_wr_data,
    output logic             xr_wr_en,
    output logic [15:0]      xr_wr_addr,
    output logic [15:0]      xr_wr_data
);
    cop_state_e       state_q, state_d;
    logic [PC_W-1:0]  pc_q, pc_d;
    logic [DW-1:0]    ir_q, w2_q;
    logic [PC_W-1:0]  mem_rd_addr;
    logic [DW-1:0]    mem_q;

    instr_kind_e      kind;
    logic [DW-1:0]    seti_target;
    logic             src_is_acc;
    logic [PC_W-1:0]  src_addr;
    logic             wait_met;
    logic             branch_taken;
    logic [PC_W-1:0]  branch_target;

    acc_op_e          acc_op;
    logic [DW-1:0]    acc;
    logic             borrow;
    logic             live;
    logic             is_set;
    logic [DW-1:0]    target;
    logic [DW-1:0]    value;

    copper_mem #(.DEPTH(CMEM_DEPTH), .AW(PC_W), .DW(DW)) u_mem (
        .clk     (clk),
        .wr_en   (cm_wr_en),
        .wr_addr (cm_wr_addr),
        .wr_data (cm_wr_data),
        .rd_addr (mem_rd_addr),
        .rd_data (mem_q)
    );

    copper_decode u_dec (
        .ir            (ir_q),
        .h_pos         (h_pos),
        .v_pos         (v_pos),
        .eol           (eol),
        .blit_busy     (blit_busy),
        .borrow        (borrow),
        .kind          (kind),
        .seti_target   (seti_target),
        .src_is_acc    (src_is_acc),
        .src_addr      (src_addr),
        .wait_met      (wait_met),
        .branch_taken  (branch_taken),
        .branch_target (branch_target)
    );

    copper_acc u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (acc_op),
        .val    (value),
        .clr_b  (!live),
        .acc    (acc),
        .borrow (borrow)
    );

    // State register and instruction latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            pc_q    <= '0;
            ir_q    <= '0;
            w2_q    <= '0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
            if (state_q == S_DECODE) ir_q <= mem_q;
            if (state_q == S_OPER)   w2_q <= mem_q;
        end
    end

    // Next state, PC and store read address
    always_comb begin
        state_d     = state_q;
        pc_d        = pc_q;
        mem_rd_addr = pc_q;
        unique case (state_q)
            S_IDLE:   state_d = S_FETCH;
            S_FETCH:  state_d = S_DECODE;
            S_DECODE: begin
                mem_rd_addr = pc_q + 11'd1;
                state_d     = S_OPER;
            end
            S_OPER: begin
                mem_rd_addr = src_addr;
                state_d     = S_EXEC;
            end
            S_EXEC: begin
                state_d = S_FETCH;
                unique case (kind)
                    K_SETI, K_SETM: pc_d = pc_q + 11'd2;
                    K_WAIT: begin
                        if (wait_met) pc_d = pc_q + 11'd1;
                        else          state_d = S_WAIT;
                    end
                    K_BRANCH: pc_d = branch_taken ? branch_target : pc_q + 11'd1;
                endcase
            end
            S_WAIT: begin
                if (wait_met) begin
                    pc_d    = pc_q + 11'd1;
                    state_d = S_FETCH;
                end
            end
            default: state_d = S_IDLE;
        endcase
        if (!en) begin
            state_d = S_IDLE;
            pc_d    = '0;
        end else if (frame_start) begin
            state_d = S_FETCH;
            pc_d    = '0;
        end
    end

    // Outputs: bus write or accumulator operation in EXEC
    always_comb begin
        live       = en && !frame_start;
        target     = (kind == K_SETI) ? seti_target : w2_q;
        value      = (kind == K_SETI) ? w2_q : (src_is_acc ? acc : mem_q);
        is_set     = live && (state_q == S_EXEC) && (kind == K_SETI || kind == K_SETM);
        acc_op     = ACC_NONE;
        if (is_set) begin
            if (target == XR_ACC_LOAD)     acc_op = ACC_LOAD;
            else if (target == XR_ACC_SUB) acc_op = ACC_SUB;
            else if (target == XR_ACC_CMP) acc_op = ACC_CMP;
        end
        xr_wr_en   = is_set && (acc_op == ACC_NONE);
        xr_wr_addr = target;
        xr_wr_data = value;
    end

    assert_idle_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (pc_q == '0) && !borrow && !xr_wr_en);

    assert_restart_on_frame_R12: assert property (@(posedge clk) disable iff (!rst_n)
        en && frame_start |=> (pc_q == '0) && !borrow && (state_q == S_FETCH));

    assert_write_slot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        xr_wr_en |-> $past(state_q, 3) == S_FETCH);

    // R5, R6 and R7: the reserved targets never reach the bus
    assert_no_reserved_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        xr_wr_en |-> (xr_wr_addr != XR_ACC_LOAD) && (xr_wr_addr != XR_ACC_SUB)
                     && (xr_wr_addr != XR_ACC_CMP));

    assert_wait_holds_pc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT) && live && !wait_met |=> $stable(pc_q) && (state_q == S_WAIT));
endmodule

// File: tb/raster_copper_bench.sv
module raster_copper_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HTOT  = 48;
    localparam int VTOT  = 8;
    localparam int DEPTH = 1536;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        frame_start = 1'b0;
    logic [10:0] h_pos = '0;
    logic [10:0] v_pos = '0;
    logic        eol = 1'b0;
    logic        blit_busy = 1'b1;
    logic        cm_wr_en = 1'b0;
    logic [10:0] cm_wr_addr = '0;
    logic [15:0] cm_wr_data = '0;
    logic        xr_wr_en;
    logic [15:0] xr_wr_addr;
    logic [15:0] xr_wr_data;

    raster_copper u_raster_copper (
        .clk(clk), .rst_n(rst_n), .en(en), .frame_start(frame_start),
        .h_pos(h_pos), .v_pos(v_pos), .eol(eol), .blit_busy(blit_busy),
        .cm_wr_en(cm_wr_en), .cm_wr_addr(cm_wr_addr), .cm_wr_data(cm_wr_data),
        .xr_wr_en(xr_wr_en), .xr_wr_addr(xr_wr_addr), .xr_wr_data(xr_wr_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    vectors = 0;
    int    miscompares = 0;
    int    cyc = 0;
    bit    finished = 0;
    string cur_req = "R1";

    logic [15:0] mmem [DEPTH];
    logic [15:0] log_addr [$];
    logic [15:0] log_data [$];
    int          log_cyc  [$];

    // Behavioural reference state
    bit          m_run = 0;
    int          m_phase = 0;
    bit          m_wait = 0;
    logic [10:0] m_pc = '0;
    logic [15:0] m_ra = '0;
    bit          m_b = 0;

    function automatic logic [15:0] mrd(input logic [10:0] a);
        if (int'(a) < DEPTH) return mmem[a];
        return 16'h0000;
    endfunction

    function automatic bit reserved(input logic [15:0] a);
        return (a == 16'hC800) || (a == 16'hC801) || (a == 16'hC7FF);
    endfunction

    task automatic model_set(output logic [15:0] a, output logic [15:0] d);
        logic [15:0] w1, w2;
        w1 = mrd(m_pc);
        w2 = mrd(m_pc + 11'd1);
        if (w1[13:12] == 2'b00) begin
            a = {w1[15:14], 2'b00, w1[11:0]};
            d = w2;
        end else begin
            a = w2;
            d = w1[11] ? m_ra : mrd(w1[10:0]);
        end
    endtask

    task automatic model_expect(output bit e, output logic [15:0] a, output logic [15:0] d);
        logic [15:0] w1;
        e = 0; a = '0; d = '0;
        w1 = mrd(m_pc);
        if (m_run && m_phase == 3 && !m_wait && en && !frame_start && !w1[13]) begin
            model_set(a, d);
            e = !reserved(a);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            m_run = 0; m_phase = 0; m_wait = 0; m_pc = '0; m_ra = '0; m_b = 0;
        end else if (!en) begin
            m_run = 0; m_phase = 0; m_wait = 0; m_pc = '0; m_b = 0;
        end else if (frame_start) begin
            m_run = 1; m_phase = 0; m_wait = 0; m_pc = '0; m_b = 0;
        end else if (!m_run) begin
            m_run = 1; m_phase = 0;
        end else if (m_phase < 3) begin
            m_phase = m_phase + 1;
        end else begin
            logic [15:0] w1, a, d;
            bit met;
            w1 = mrd(m_pc);
            if (!w1[13]) begin
                model_set(a, d);
                if (a == 16'hC800) begin
                    m_ra = d; m_b = 0;
                end else if (a == 16'hC801) begin
                    m_b = (m_ra < d); m_ra = m_ra - d;
                end else if (a == 16'hC7FF) begin
                    m_b = (m_ra < d);
                end
                m_pc = m_pc + 11'd2; m_phase = 0;
            end else if (!w1[12]) begin
                if (w1[11]) met = (v_pos >= {1'b0, w1[9:0]}) || (w1[10] && !blit_busy);
                else        met = (h_pos >= w1[10:0]) || eol;
                if (met) begin
                    m_pc = m_pc + 11'd1; m_phase = 0; m_wait = 0;
                end else begin
                    m_wait = 1;
                end
            end else begin
                if (w1[11] ? m_b : !m_b) m_pc = w1[10:0];
                else                     m_pc = m_pc + 11'd1;
                m_phase = 0;
            end
        end
    end

    // Raster stimulus, then per-cycle comparison away from the clock edge
    always @(negedge clk) begin
        bit e;
        logic [15:0] a, d;
        if (h_pos == 11'(HTOT-1)) begin
            h_pos <= '0;
            v_pos <= (v_pos == 11'(VTOT-1)) ? 11'd0 : v_pos + 11'd1;
            eol   <= 1'b0;
        end else begin
            h_pos <= h_pos + 11'd1;
            eol   <= (h_pos == 11'(HTOT-2));
        end
        #1;
        if (rst_n && !finished) begin
            model_expect(e, a, d);
            vectors++;
            if (xr_wr_en !== e || (e && (xr_wr_addr !== a || xr_wr_data !== d))) begin
                miscompares++;
                $display("FAIL %s: cycle %0d bus en=%b addr=%h data=%h, expected en=%b addr=%h data=%h",
                         cur_req, cyc, xr_wr_en, xr_wr_addr, xr_wr_data, e, a, d);
            end
            if (xr_wr_en === 1'b1) begin
                log_addr.push_back(xr_wr_addr);
                log_data.push_back(xr_wr_data);
                log_cyc.push_back(cyc);
            end
        end
    end

    task automatic check(input string req, input bit ok, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic expect_write(input string req, input int idx, input logic [15:0] a,
                                input logic [15:0] d);
        if (idx >= log_addr.size()) begin
            check(req, 0, log_addr.size(), idx + 1);
        end else begin
            check(req, log_addr[idx] == a, int'(log_addr[idx]), int'(a));
            check(req, log_data[idx] == d, int'(log_data[idx]), int'(d));
        end
    endtask

    task automatic load(input int addr, input logic [15:0] data);
        @(negedge clk);
        cm_wr_en   = 1'b1;
        cm_wr_addr = 11'(addr);
        cm_wr_data = data;
        mmem[addr] = data;
    endtask

    task automatic clear_log();
        log_addr.delete(); log_data.delete(); log_cyc.delete();
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int c0;
        for (int i = 0; i < DEPTH; i++) mmem[i] = 16'h0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #2;
        check("R1", xr_wr_en === 1'b0, int'(xr_wr_en), 0);

        // Program one: immediates, accumulator ops, branches, waits
        cur_req = "R13";
        load(0,  16'h0123); load(1,  16'hBEEF);   // R2 set-immediate
        load(2,  16'hC800); load(3,  16'h0005);   // R5 load 5
        load(4,  16'h1800); load(5,  16'h0200);   // R4 copy accumulator
        load(6,  16'hC801); load(7,  16'h0007);   // R6 5-7 -> FFFE, borrow 1
        load(8,  16'h380B);                       // R10 branch on borrow to 11
        load(9,  16'h0300); load(10, 16'hDEAD);   // skipped
        load(11, 16'h1800); load(12, 16'h0201);
        load(13, 16'hC7FF); load(14, 16'h0001);   // R7 compare -> borrow 0
        load(15, 16'h3012);                       // branch if no borrow to 18
        load(16, 16'h0301); load(17, 16'h0001);   // skipped
        load(18, 16'h1020); load(19, 16'h0202);   // R3 copy from store
        load(20, 16'h201E);                       // R8 horizontal wait 30
        load(21, 16'h0400); load(22, 16'h0001);
        load(23, 16'h2C03);                       // R9 vertical wait 3, blit exit
        load(24, 16'h0401); load(25, 16'h0002);
        load(26, 16'h301A);                       // spin
        load(32, 16'h1234);
        @(negedge clk);
        cm_wr_en = 1'b0;

        cur_req = "R11";
        clear_log();
        @(negedge clk);
        en = 1'b1;
        c0 = cyc;
        repeat (600) @(negedge clk);
        check("R11", log_cyc.size() > 0 && log_cyc[0] - c0 == 4,
              log_cyc.size() > 0 ? log_cyc[0] - c0 : -1, 4);
        expect_write("R2", 0, 16'h0123, 16'hBEEF);
        expect_write("R4", 1, 16'h0200, 16'h0005);
        expect_write("R6", 2, 16'h0201, 16'hFFFE);
        expect_write("R3", 3, 16'h0202, 16'h1234);
        expect_write("R8", 4, 16'h0400, 16'h0001);
        expect_write("R9", 5, 16'h0401, 16'h0002);
        check("R10", log_addr.size() == 6, log_addr.size(), 6);

        // Restart at top of frame with the blitter idle
        cur_req = "R12";
        blit_busy = 1'b0;
        while (!(h_pos == 11'(HTOT-1) && v_pos == 11'(VTOT-1))) @(negedge clk);
        clear_log();
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        repeat (110) @(negedge clk);
        expect_write("R12", 0, 16'h0123, 16'hBEEF);
        check("R9", log_addr.size() == 6 && v_pos < 11'd3, log_addr.size(), 6);

        // Disable, then program two
        cur_req = "R1";
        en = 1'b0;
        clear_log();
        repeat (5) @(negedge clk);
        check("R1", log_addr.size() == 0, log_addr.size(), 0);
        cur_req = "R13";
        load(0,  16'h1700); load(1,  16'h0210);   // R13 read beyond depth
        load(2,  16'hC800); load(3,  16'h0003);
        load(4,  16'hC801); load(5,  16'h0003);   // R6 equal: 0, borrow 0
        load(6,  16'h1800); load(7,  16'h0211);
        load(8,  16'hC7FF); load(9,  16'h0009);   // R7 borrow 1, acc kept
        load(10, 16'h1800); load(11, 16'h0212);
        load(12, 16'h380F);                       // branch on borrow to 15
        load(13, 16'h0300); load(14, 16'hDEAD);
        load(15, 16'h203C);                       // R8 wait 60, ends on eol
        load(16, 16'h0213); load(17, 16'h0007);
        load(18, 16'h3812);
        @(negedge clk);
        cm_wr_en = 1'b0;
        cur_req = "R7";
        en = 1'b1;
        repeat (150) @(negedge clk);
        expect_write("R13", 0, 16'h0210, 16'h0000);
        expect_write("R6", 1, 16'h0211, 16'h0000);
        expect_write("R7", 2, 16'h0212, 16'h0000);
        expect_write("R8", 3, 16'h0213, 16'h0007);
        check("R10", log_addr.size() == 4, log_addr.size(), 4);
        summary();
    end
endmodule